// File: doc/BRIEF.md
# Two-Phase Adaptive Clock Recovery Controller

This block rebuilds a local service clock whose frequency follows a remote service clock that is only visible through a packet network. A 48-bit phase accumulator runs from the 38.88 MHz reference clock and acts as a numerically controlled oscillator. Its carry out is the recovered clock enable. The frequency word is a nominal word plus a signed correction, and a proportional-integral loop filter produces that correction. The filter uses arithmetic shifts for its gains. With the default 48-bit accumulator, one step of the frequency word is far below one part per billion of the nominal rate.

The controller has two named states. In `PH_ACQUIRE` it is filling in the frequency: each valid sample of the frequency-error estimate goes into the filter using the acquisition gain pair. A mode input chooses where that estimate comes from. It can be the timestamp-derived error, used when both ends share a common reference, or the arrival-timing error, used in adaptive operation. A lock monitor counts consecutive samples whose error magnitude is under a programmable lock threshold. When the count reaches `LOCK_N`, the `ACQ_TO_TRACK` transition moves the controller to `PH_TRACK`. In `PH_TRACK` the filter is fed the jitter-buffer fill level minus its target, using the tracking gain pair. This holds the buffer at its target level. The `TRACK_TO_ACQ` transition returns to acquisition when a sample's frequency-error magnitude exceeds a larger unlock threshold. The integrator is kept as it is across both transitions, so the frequency word does not jump at a transition.

The correction is limited to ±90 ppm of the nominal word in use. A high-speed input switches the nominal word from the low-speed service rate (2.048 MHz by default) to a high-speed line rate divided by 12 (34.368 MHz / 12 by default). The limit switches with it.

Top module: `clkrec_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in `PH_ACQUIRE`, clears the integrator, the correction, the lock run count and the accumulator, and drives `locked` = 0, `rclk_en` = 0 and `freq_word` = the nominal word.
- R2: `diff_mode` = 1 selects `ts_err` as the frequency-error sample and `diff_mode` = 0 selects `arr_err`. Both are 24-bit two's complement numbers, and the unselected one has no effect.
- R3: On a valid sample in `PH_ACQUIRE` with error e, the integrator becomes clip(I + (e >>> KI_ACQ)) and the correction becomes clip(I_new + (e >>> KP_ACQ)). Both are updated at that edge, and `freq_word` = nominal + correction from the next cycle on.
- R4: The `ACQ_TO_TRACK` transition happens at the edge of the LOCK_N-th consecutive valid sample whose error magnitude is strictly below `lock_thr`. Any valid sample at or above `lock_thr` restarts the count. Cycles with no sample do not break the run.
- R5: In `PH_TRACK` the filter error is `fill_lvl` − `fill_tgt`, taken as unsigned 16-bit values, and the KP_TRK/KI_TRK gains apply. The frequency-error sample does not reach the filter.
- R6: In `PH_TRACK`, a valid sample whose frequency-error magnitude is strictly above `unlock_thr` causes the `TRACK_TO_ACQ` transition at that edge, and the lock run count restarts from zero.
- R7: The integrator keeps its value across both transitions. The sample taken at a transition edge is processed using the phase that was active before that edge.
- R8: The integrator and the correction are each clipped to ±LIM, where LIM = floor(nominal × 90 / 1 000 000) for the nominal word in use.
- R9: `hs_mode` = 0 selects the nominal word floor(2^48 × 2048 / 38880). `hs_mode` = 1 selects floor(2^48 × 2864 / 38880). The change takes effect in the same cycle, and so does the matching LIM.
- R10: Each cycle the accumulator adds `freq_word` modulo 2^48. `rclk_en` is high in the cycle after an addition that carried out of bit 47.
- R11: A cycle with `smp_vld` = 0 changes neither the correction nor the phase nor the lock run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 38.88 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Error and fill samples are valid this cycle |
| diff_mode | input | 1 | 1: timestamp error source, 0: arrival-timing error source |
| hs_mode | input | 1 | 1: high-speed nominal word and limit |
| ts_err | input | 24 | Timestamp-derived frequency error, two's complement |
| arr_err | input | 24 | Arrival-timing frequency error, two's complement |
| fill_lvl | input | 16 | Jitter-buffer fill level |
| fill_tgt | input | 16 | Jitter-buffer fill target |
| lock_thr | input | 24 | Lock threshold on error magnitude (unsigned) |
| unlock_thr | input | 24 | Unlock threshold on error magnitude (unsigned) |
| rclk_en | output | 1 | Recovered clock enable, one pulse per accumulator carry |
| locked | output | 1 | 1 in `PH_TRACK`, 0 in `PH_ACQUIRE` |
| freq_word | output | 48 | Current frequency word |

## Verification
The bench aims at the edges of the lock run. It sends LOCK_N − 1 good samples and then one bad one, and it places idle gaps inside a run. A design that fails to restart the count, or that counts idle cycles, would lock early. A design that compared with `<=` would lock one sample too soon on a sample equal to the threshold. The bench drives the integrator against both clip limits and then flips `hs_mode` while the integrator is held there. A design without anti-windup, or one that kept the old limit, would show a word outside ±90 ppm, or would take extra time to leave saturation. The bench also checks the cycles around each phase transition against the reference model. A design that cleared the integrator at a transition, or used the new phase's gains on the sample taken at the transition edge, would show a step in `freq_word`.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

    // Loop phase of the controller.
    typedef enum logic [0:0] {
        PH_ACQUIRE = 1'b0,
        PH_TRACK   = 1'b1
    } phase_t;

endpackage

// File: rtl/clkrec_lock_mon.sv
module clkrec_lock_mon
    import clkrec_pkg::*;
#(
    parameter int ERR_W  = 24,
    parameter int LOCK_N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  phase_t           phase,
    input  logic [ERR_W:0]   err_mag,
    input  logic [ERR_W-1:0] lock_thr,
    input  logic [ERR_W-1:0] unlock_thr,
    output logic             lock_hit,
    output logic             unlock_hit
);
    localparam int CNT_W = $clog2(LOCK_N + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_N - 1);

    logic [CNT_W-1:0] run_q;
    logic             below_lock;
    logic             above_unlock;

    assign below_lock   = err_mag < {1'b0, lock_thr};
    assign above_unlock = err_mag > {1'b0, unlock_thr};

    assign lock_hit   = smp && (phase == PH_ACQUIRE) && below_lock && (run_q == LAST);
    assign unlock_hit = smp && (phase == PH_TRACK) && above_unlock;

    // Run of consecutive good samples, only counted while acquiring.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (phase != PH_ACQUIRE) begin
            run_q <= '0;
        end else if (smp) begin
            if (!below_lock || lock_hit) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkrec_pi_filter.sv
module clkrec_pi_filter
    import clkrec_pkg::*;
#(
    parameter int INT_W  = 40,
    parameter int KP_ACQ = 2,
    parameter int KI_ACQ = 4,
    parameter int KP_TRK = 6,
    parameter int KI_TRK = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp,
    input  phase_t                  phase,
    input  logic signed [INT_W-1:0] err,
    input  logic signed [INT_W-1:0] lim,
    output logic signed [INT_W-1:0] corr
);
    logic signed [INT_W-1:0] integ_q;
    logic signed [INT_W-1:0] corr_q;
    logic signed [INT_W-1:0] i_step;
    logic signed [INT_W-1:0] p_term;
    logic signed [INT_W-1:0] integ_d;
    logic signed [INT_W-1:0] corr_d;

    function automatic logic signed [INT_W-1:0] clip(
        input logic signed [INT_W-1:0] v,
        input logic signed [INT_W-1:0] l
    );
        if (v > l) begin
            return l;
        end else if (v < -l) begin
            return -l;
        end
        return v;
    endfunction

    // Gain pair follows the phase that is active at this edge.
    always_comb begin
        unique case (phase)
            PH_ACQUIRE: begin
                i_step = err >>> KI_ACQ;
                p_term = err >>> KP_ACQ;
            end
            PH_TRACK: begin
                i_step = err >>> KI_TRK;
                p_term = err >>> KP_TRK;
            end
        endcase
        integ_d = clip(integ_q + i_step, lim);
        corr_d  = clip(integ_d + p_term, lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            corr_q  <= '0;
        end else if (smp) begin
            integ_q <= integ_d;
            corr_q  <= corr_d;
        end
    end

    assign corr = corr_q;

endmodule

// File: rtl/clkrec_nco.sv
module clkrec_nco #(
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] fw,
    output logic             carry_en
);
    logic [ACC_W-1:0] acc_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            en_q  <= 1'b0;
        end else begin
            {en_q, acc_q} <= {1'b0, acc_q} + {1'b0, fw};
        end
    end

    assign carry_en = en_q;

endmodule

// File: rtl/clkrec_ctrl.sv
module clkrec_ctrl
    import clkrec_pkg::*;
#(
    parameter int          ACC_W   = 48,
    parameter int          ERR_W   = 24,
    parameter int          FILL_W  = 16,
    parameter int          LOCK_N  = 8,
    parameter int          KP_ACQ  = 2,
    parameter int          KI_ACQ  = 4,
    parameter int          KP_TRK  = 6,
    parameter int          KI_TRK  = 10,
    parameter int          PPM_LIM = 90,
    parameter logic [63:0] NOM_LS  = (64'd1 << 48) * 64'd2048 / 64'd38880,
    parameter logic [63:0] NOM_HS  = (64'd1 << 48) * 64'd2864 / 64'd38880
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic              diff_mode,
    input  logic              hs_mode,
    input  logic [ERR_W-1:0]  ts_err,
    input  logic [ERR_W-1:0]  arr_err,
    input  logic [FILL_W-1:0] fill_lvl,
    input  logic [FILL_W-1:0] fill_tgt,
    input  logic [ERR_W-1:0]  lock_thr,
    input  logic [ERR_W-1:0]  unlock_thr,
    output logic              rclk_en,
    output logic              locked,
    output logic [ACC_W-1:0]  freq_word
);
    localparam int          INT_W  = ACC_W - 8;
    localparam logic [63:0] LIM_LS = NOM_LS * 64'(PPM_LIM) / 64'd1000000;
    localparam logic [63:0] LIM_HS = NOM_HS * 64'(PPM_LIM) / 64'd1000000;

    phase_t state_q;
    phase_t state_d;

    logic [ERR_W-1:0]        fe_sel;
    logic signed [ERR_W:0]   fe_ext;
    logic [ERR_W:0]          fe_mag;
    logic signed [FILL_W:0]  fill_err;
    logic signed [INT_W-1:0] loop_err;
    logic signed [INT_W-1:0] lim_sel;
    logic signed [INT_W-1:0] corr;
    logic [ACC_W-1:0]        nom_sel;
    logic                    lock_hit;
    logic                    unlock_hit;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions ACQ_TO_TRACK and TRACK_TO_ACQ.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ACQUIRE: if (lock_hit)   state_d = PH_TRACK;
            PH_TRACK:   if (unlock_hit) state_d = PH_ACQUIRE;
        endcase
    end

    // Outputs and error routing.
    always_comb begin
        fe_sel   = diff_mode ? ts_err : arr_err;
        fe_ext   = $signed({fe_sel[ERR_W-1], fe_sel});
        fe_mag   = fe_ext[ERR_W] ? $unsigned(-fe_ext) : $unsigned(fe_ext);
        fill_err = $signed({1'b0, fill_lvl}) - $signed({1'b0, fill_tgt});
        unique case (state_q)
            PH_ACQUIRE: loop_err = INT_W'(fe_ext);
            PH_TRACK:   loop_err = INT_W'(fill_err);
        endcase
        nom_sel   = hs_mode ? NOM_HS[ACC_W-1:0] : NOM_LS[ACC_W-1:0];
        lim_sel   = hs_mode ? $signed(LIM_HS[INT_W-1:0]) : $signed(LIM_LS[INT_W-1:0]);
        freq_word = nom_sel + {{(ACC_W - INT_W){corr[INT_W-1]}}, corr};
        locked    = (state_q == PH_TRACK);
    end

    clkrec_lock_mon #(
        .ERR_W (ERR_W),
        .LOCK_N(LOCK_N)
    ) u_lock (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp_vld),
        .phase     (state_q),
        .err_mag   (fe_mag),
        .lock_thr  (lock_thr),
        .unlock_thr(unlock_thr),
        .lock_hit  (lock_hit),
        .unlock_hit(unlock_hit)
    );

    clkrec_pi_filter #(
        .INT_W (INT_W),
        .KP_ACQ(KP_ACQ),
        .KI_ACQ(KI_ACQ),
        .KP_TRK(KP_TRK),
        .KI_TRK(KI_TRK)
    ) u_filt (
        .clk  (clk),
        .rst  (rst),
        .smp  (smp_vld),
        .phase(state_q),
        .err  (loop_err),
        .lim  (lim_sel),
        .corr (corr)
    );

    clkrec_nco #(
        .ACC_W(ACC_W)
    ) u_nco (
        .clk     (clk),
        .rst     (rst),
        .fw      (freq_word),
        .carry_en(rclk_en)
    );

endmodule

// File: rtl/clkrec_ctrl_chk.sv
module clkrec_ctrl_chk #(
    parameter int          ACC_W   = 48,
    parameter int          ERR_W   = 24,
    parameter int          PPM_LIM = 90,
    parameter logic [63:0] NOM_LS  = 64'd0,
    parameter logic [63:0] NOM_HS  = 64'd0
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             diff_mode,
    input logic             hs_mode,
    input logic [ERR_W-1:0] ts_err,
    input logic [ERR_W-1:0] arr_err,
    input logic [ERR_W-1:0] lock_thr,
    input logic [ERR_W-1:0] unlock_thr,
    input logic             rclk_en,
    input logic             locked,
    input logic [ACC_W-1:0] freq_word
);
    localparam logic [63:0] LIM_LS = NOM_LS * 64'(PPM_LIM) / 64'd1000000;
    localparam logic [63:0] LIM_HS = NOM_HS * 64'(PPM_LIM) / 64'd1000000;

    logic [63:0]          nom;
    logic [63:0]          lim;
    logic [63:0]          fw64;
    logic signed [ERR_W:0] se;
    logic [ERR_W:0]        mag;

    always_comb begin
        nom  = hs_mode ? NOM_HS : NOM_LS;
        lim  = hs_mode ? LIM_HS : LIM_LS;
        fw64 = 64'(freq_word);
        se   = diff_mode ? $signed({ts_err[ERR_W-1], ts_err}) : $signed({arr_err[ERR_W-1], arr_err});
        mag  = se[ERR_W] ? $unsigned(-se) : $unsigned(se);
    end

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (!locked && !rclk_en && fw64 == nom)); // R1

    AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (fw64 >= nom - lim) && (fw64 <= nom + lim)); // R8

    AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> (!$stable(hs_mode) || $stable(freq_word))); // R11

    AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(locked)); // R11

    AST_LOCK_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(smp_vld)); // R4

    AST_NO_LOCK_ON_BIG_ERR: assert property (@(posedge clk) disable iff (rst)
        (!locked && smp_vld && mag >= {1'b0, lock_thr}) |=> !locked); // R4

    AST_UNLOCK_ON_BIG_ERR: assert property (@(posedge clk) disable iff (rst)
        (locked && smp_vld && mag > {1'b0, unlock_thr}) |=> !locked); // R6

endmodule

bind clkrec_ctrl clkrec_ctrl_chk #(
    .ACC_W  (ACC_W),
    .ERR_W  (ERR_W),
    .PPM_LIM(PPM_LIM),
    .NOM_LS (NOM_LS),
    .NOM_HS (NOM_HS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .diff_mode (diff_mode),
    .hs_mode   (hs_mode),
    .ts_err    (ts_err),
    .arr_err   (arr_err),
    .lock_thr  (lock_thr),
    .unlock_thr(unlock_thr),
    .rclk_en   (rclk_en),
    .locked    (locked),
    .freq_word (freq_word)
);

// File: tb/clkrec_ctrl_test.sv
module clkrec_ctrl_test;
    localparam int CLK_P  = 10;
    localparam int LOCK_N = 8;
    localparam int KP_A = 2, KI_A = 4, KP_T = 6, KI_T = 10;
    localparam longint MASK   = (64'sd1 <<< 48) - 1;
    localparam longint NOM_L  = (64'sd1 <<< 48) * 2048 / 38880;
    localparam longint NOM_H  = (64'sd1 <<< 48) * 2864 / 38880;
    localparam longint LIM_L  = NOM_L * 90 / 1000000;
    localparam longint LIM_H  = NOM_H * 90 / 1000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0, diff_mode = 1'b1, hs_mode = 1'b0;
    logic [23:0] ts_err = '0, arr_err = '0, lock_thr = 24'd1000, unlock_thr = 24'd50000;
    logic [15:0] fill_lvl = 16'd1000, fill_tgt = 16'd1000;
    logic        rclk_en, locked;
    logic [47:0] freq_word;

    int    vectors = 0, fails = 0;
    bit    done = 1'b0;
    string req = "R1";

    // Reference model state.
    int     m_ph = 0, m_run = 0;
    longint m_int = 0, m_corr = 0, m_acc = 0;
    bit     m_en = 1'b0;

    clkrec_ctrl #(.LOCK_N(LOCK_N), .KP_ACQ(KP_A), .KI_ACQ(KI_A), .KP_TRK(KP_T), .KI_TRK(KI_T)) uut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .diff_mode(diff_mode), .hs_mode(hs_mode),
        .ts_err(ts_err), .arr_err(arr_err), .fill_lvl(fill_lvl), .fill_tgt(fill_tgt),
        .lock_thr(lock_thr), .unlock_thr(unlock_thr),
        .rclk_en(rclk_en), .locked(locked), .freq_word(freq_word)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic longint clip(longint v, longint l);
        if (v > l) return l;
        if (v < -l) return -l;
        return v;
    endfunction

    function automatic longint model_fw();
        return ((hs_mode ? NOM_H : NOM_L) + m_corr) & MASK;
    endfunction

    always @(posedge clk) begin : model
        longint fe, a, e, sum, lim;
        int     kp, ki;
        if (rst) begin
            m_ph = 0; m_run = 0; m_int = 0; m_corr = 0; m_acc = 0; m_en = 1'b0;
        end else begin
            sum   = m_acc + model_fw();
            m_en  = sum[48];
            m_acc = sum & MASK;
            if (smp_vld) begin
                fe  = diff_mode ? longint'($signed(ts_err)) : longint'($signed(arr_err));
                a   = (fe < 0) ? -fe : fe;
                lim = hs_mode ? LIM_H : LIM_L;
                if (m_ph == 0) begin e = fe; kp = KP_A; ki = KI_A; end
                else begin e = longint'(fill_lvl) - longint'(fill_tgt); kp = KP_T; ki = KI_T; end
                m_int  = clip(m_int + (e >>> ki), lim);
                m_corr = clip(m_int + (e >>> kp), lim);
                if (m_ph == 0) begin
                    if (a < longint'(lock_thr)) begin
                        m_run++;
                        if (m_run == LOCK_N) begin m_ph = 1; m_run = 0; end
                    end else m_run = 0;
                end else if (a > longint'(unlock_thr)) begin
                    m_ph = 0; m_run = 0;
                end
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) if (!done) begin
        vectors++;
        if (freq_word !== m_fw_bits()) begin
            fails++;
            $display("FAIL %s freq_word got %0h exp %0h", req, freq_word, m_fw_bits());
        end
        if (locked !== (m_ph == 1)) begin
            fails++;
            $display("FAIL %s locked got %0b exp %0b", req, locked, m_ph == 1);
        end
        if (rclk_en !== m_en) begin
            fails++;
            $display("FAIL %s rclk_en got %0b exp %0b", req, rclk_en, m_en);
        end
    end

    function automatic logic [47:0] m_fw_bits();
        longint v;
        v = model_fw();
        return v[47:0];
    endfunction

    task automatic chk(string r, longint got, longint exp, string what);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d exp %0d", r, what, got, exp);
        end
    endtask

    task automatic smp(logic [23:0] ts, logic [23:0] arr, logic [15:0] fl);
        @(posedge clk); #1;
        smp_vld = 1'b1; ts_err = ts; arr_err = arr; fill_lvl = fl;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            smp_vld = 1'b0; ts_err = 24'h5A5A5A; arr_err = 24'hA5A5A5;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired in %s", req);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", longint'(freq_word), NOM_L, "reset freq_word");
        chk("R1", longint'(locked), 0, "reset locked");
        chk("R1", longint'(rclk_en), 0, "reset rclk_en");

        // R3 and R2: acquisition with timestamp source, arrival value ignored
        req = "R3";
        for (int i = 0; i < 20; i++) smp(24'd200000, -24'sd300000, 16'd7);
        idle(5);
        req = "R11";
        idle(10);
        req = "R2";
        diff_mode = 1'b0;
        for (int i = 0; i < 20; i++) smp(24'd777777, -24'sd150000, 16'd0);
        for (int i = 0; i < 16; i++) smp(24'd0, (i % 2) ? 24'd90000 : -24'sd41234, 16'd0);
        idle(1);
        @(negedge clk);
        chk("R2", longint'(locked), 0, "locked after large errors");

        // R4: lock run edges
        req = "R4";
        diff_mode = 1'b1;
        for (int i = 0; i < LOCK_N - 1; i++) smp(24'd500, 24'd0, 16'd0);
        smp(24'd1000, 24'd0, 16'd0);            // equal to threshold: restarts run
        idle(1);
        @(negedge clk);
        chk("R4", longint'(locked), 0, "locked after run broken at threshold");
        for (int i = 0; i < LOCK_N - 1; i++) begin
            smp(-24'sd999, 24'd0, 16'd0);
            idle(2);
        end
        @(negedge clk);
        chk("R4", longint'(locked), 0, "locked one sample early");
        req = "R7";
        smp(24'd300, 24'd0, 16'd0);
        idle(1);
        @(negedge clk);
        chk("R4", longint'(locked), 1, "locked after LOCK_N good samples");

        // R5: tracking on fill error, frequency error ignored by the filter
        req = "R5";
        for (int i = 0; i < 40; i++)
            smp((i % 2) ? 24'd20000 : -24'sd30000, 24'd0, 16'(1000 + i * 37 - 700));
        smp(24'd45000, 24'd0, 16'd1000);
        idle(1);
        @(negedge clk);
        chk("R5", longint'(locked), 1, "still locked in tracking");

        // R6: unlock on large error, R7 integrator carried back
        req = "R6";
        smp(24'd50000, 24'd0, 16'd1200);      // equal to unlock threshold: stays
        smp(24'd50001, 24'd0, 16'd1200);      // above: falls back
        idle(1);
        @(negedge clk);
        chk("R6", longint'(locked), 0, "locked after unlock sample");
        req = "R7";
        for (int i = 0; i < 5; i++) smp(24'd100, 24'd0, 16'd0);

        // R8: saturation both ways, R9 high-speed limit
        req = "R8";
        lock_thr = 24'd0;
        for (int i = 0; i < 3000; i++) smp(24'h7FFFFF, 24'd0, 16'd0);
        idle(1);
        @(negedge clk);
        chk("R8", longint'(freq_word), NOM_L + LIM_L, "upper clip");
        for (int i = 0; i < 6000; i++) smp(24'h800000, 24'd0, 16'd0);
        idle(1);
        @(negedge clk);
        chk("R8", longint'(freq_word), NOM_L - LIM_L, "lower clip");
        req = "R9";
        hs_mode = 1'b1;
        @(negedge clk);
        chk("R9", longint'(freq_word), NOM_H - LIM_L, "hs nominal switch");
        for (int i = 0; i < 1500; i++) smp(24'h800000, 24'd0, 16'd0);
        idle(1);
        @(negedge clk);
        chk("R9", longint'(freq_word), NOM_H - LIM_H, "hs lower clip");

        // R1 again mid-run, then R10 long free run
        req = "R1";
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk("R1", longint'(freq_word), NOM_H, "reset freq_word hs");
        chk("R1", longint'(locked), 0, "reset locked mid-run");
        hs_mode = 1'b0;
        req = "R10";
        idle(2000);
        lock_thr = 24'd1000;
        for (int i = 0; i < 30; i++) smp(24'(i * 13), 24'd0, 16'd1000);
        idle(200);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule